// File: doc/BRIEF.md
# Host Response Timeout Timer

This block watches a parallel-port peripheral's handshake with a remote host. The port sequencer that drives the handshake pulses `arm_start` whenever it enters a step that waits for a host-generated event. It pulses `host_ack` when that event arrives. Between the two, a free-running prescaler divides the system clock and advances a timeout counter. The counter's upper bits are compared against a programmable timeout value. If the host has not answered when they match, the block sets a sticky timeout flag, which drives `irq` to the local CPU.

A small register bus gives software three registers. The timeout value sits at 0x24 and resets to all ones. An address holding register sits at 0x25. A status word sits at 0x26. The address register is loaded from the port side whenever the host performs an address write. It is presented back to the port for address reads, and software may also read and write it. With the default parameters the prescaler divides by 2048, the counter is 14 bits wide and the timeout value is 8 bits, compared against the counter's top 8 bits.

Top module: `host_resp_timer`

## Requirements
- R1: After reset, the timeout value register reads all ones (0xFF with defaults, 0x07 with VAL_W=3), the address register reads 0x00, the status word reads 0, `irq` is low and `tmr_busy` is low.
- R2: An `arm_start` pulse clears the prescaler and counter and sets `tmr_busy` on the next edge, even if the timer is already running. When `arm_start` and `host_ack` are high together, the restart wins.
- R3: With timeout value v, P = 2^PRE_W and L = CNT_W - VAL_W, `irq` rises exactly (v*2^L + 1)*P clock edges after the edge that samples `arm_start`. In particular, v = 0 expires on the first prescaled tick, P edges after start.
- R4: A `host_ack` sampled while the timer runs stops it (`tmr_busy` low) and prevents expiry. This includes an ack sampled on the very edge of expiry.
- R5: The timeout flag stays set until a bus write to 0x26 with bit 0 = 1. A write with bit 0 = 0 leaves it set. If an expiry and a clearing write fall on the same edge, the flag ends up set.
- R6: On expiry the timer halts (`tmr_busy` low) and does not wrap or expire again until the next `arm_start`. The flag stays clear after software clears it.
- R7: Register reads are combinational: 0x24 returns the timeout value zero-extended, 0x25 returns the address register, and 0x26 returns {6'b0, busy, flag}. Any other address reads 0. A write to 0x24 keeps only the low VAL_W bits.
- R8: `epp_addr_wr` loads `epp_addr_in` into the address register, which drives `epp_addr_out` and reads back at 0x25. A bus write to 0x25 also loads it. When both happen on the same edge, the port-side value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_start | input | 1 | Pulse from the port sequencer: a host-response step has begun |
| host_ack | input | 1 | Pulse: the awaited host event arrived |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| epp_addr_wr | input | 1 | Port side: host address write, load the address register |
| epp_addr_in | input | 8 | Port side: address byte from the host |
| epp_addr_out | output | 8 | Port side: address register contents for host reads |
| tmr_busy | output | 1 | Timer is counting |
| irq | output | 1 | Timeout flag, interrupt to the local CPU |

## Verification
The bench builds the timer with PRE_W=2, CNT_W=5 and VAL_W=3. That gives a divide-by-4 prescaler and a 3-bit value compared against the top 3 of 5 counter bits, so the longest timeout is 116 cycles. This lets the bench sweep every timeout value, measuring the exact expiry edge and applying an ack on that very edge. Restart, flag set-versus-clear collisions and no-wrap behaviour after expiry are all reached within a few thousand cycles.

// File: rtl/host_resp_timer.sv
module host_resp_timer #(
  parameter int PRE_W     = 11,
  parameter int CNT_W     = 14,
  parameter int VAL_W     = 8,
  parameter logic [7:0] TVAL_ADDR = 8'h24,
  parameter logic [7:0] EADR_ADDR = 8'h25,
  parameter logic [7:0] STAT_ADDR = 8'h26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_start,
  input  logic       host_ack,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       epp_addr_wr,
  input  logic [7:0] epp_addr_in,
  output logic [7:0] epp_addr_out,
  output logic       tmr_busy,
  output logic       irq
);
  localparam int HI_LSB = CNT_W - VAL_W;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VAL_W-1:0] tval_q;
  logic [7:0]       eaddr_q;
  logic             run_q, flag_q;

  wire tick   = run_q && (&pre_q);
  wire match  = cnt_q[CNT_W-1:HI_LSB] == tval_q;
  wire expire = tick && match && !host_ack && !arm_start;
  wire clr    = bus_wr && bus_addr == STAT_ADDR && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_start) begin
      pre_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (host_ack || (tick && match)) begin
        run_q <= 1'b0;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (tick) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tval_q  <= '1;
      eaddr_q <= '0;
    end else begin
      if (bus_wr && bus_addr == TVAL_ADDR) tval_q <= bus_wdata[VAL_W-1:0];
      if (epp_addr_wr) eaddr_q <= epp_addr_in;
      else if (bus_wr && bus_addr == EADR_ADDR) eaddr_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      TVAL_ADDR: bus_rdata[VAL_W-1:0] = tval_q;
      EADR_ADDR: bus_rdata = eaddr_q;
      STAT_ADDR: bus_rdata[1:0] = {run_q, flag_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign epp_addr_out = eaddr_q;
  assign tmr_busy     = run_q;
  assign irq          = flag_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_start |=> (run_q && cnt_q == '0 && pre_q == '0)); // R2
  AST_ACK_IN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !flag_q) |=> !flag_q); // R4
  AST_ACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && host_ack && !arm_start) |=> !run_q); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(bus_wr && bus_addr == STAT_ADDR && bus_wdata[0])) |=> flag_q); // R5
  AST_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !arm_start) |=> ($stable(cnt_q) && !run_q)); // R6
  AST_RISE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> !run_q); // R6
endmodule

// File: tb/host_resp_timer_test.sv
module host_resp_timer_test;
  localparam int CLK_P = 10;
  localparam int PW = 2, CW = 5, VW = 3;
  localparam int P = 1 << PW;
  localparam int L = CW - VW;

  logic clk = 0, rst_n = 0, arm_start = 0, host_ack = 0, bus_wr = 0, epp_addr_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, epp_addr_in = 0;
  logic [7:0] bus_rdata, epp_addr_out;
  logic tmr_busy, irq;
  int checks = 0, errors = 0;

  host_resp_timer #(.PRE_W(PW), .CNT_W(CW), .VAL_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .arm_start(arm_start), .host_ack(host_ack),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .epp_addr_wr(epp_addr_wr), .epp_addr_in(epp_addr_in), .epp_addr_out(epp_addr_out),
    .tmr_busy(tmr_busy), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic start();
    arm_start = 1;
    @(negedge clk);
    arm_start = 0;
  endtask

  function automatic int dur(input int v);
    return (v * (1 << L) + 1) * P;
  endfunction

  logic [7:0] r;

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h24, r); chk(r == 8'h07, "R1 tval reset", r, 7);
    rd(8'h25, r); chk(r == 8'h00, "R1 addr reset", r, 0);
    rd(8'h26, r); chk(r == 8'h00, "R1 status reset", r, 0);
    chk(!irq && !tmr_busy, "R1 outputs reset", {irq, tmr_busy}, 0);

    wr(8'h24, 8'hFD); rd(8'h24, r); chk(r == 8'h05, "R7 tval low bits", r, 5);
    rd(8'h31, r); chk(r == 8'h00, "R7 unmapped", r, 0);

    for (int v = 0; v < (1 << VW); v++) begin
      wr(8'h24, 8'(v));
      start();
      chk(tmr_busy, "R2 busy after start", tmr_busy, 1);
      repeat (dur(v) - 1) @(negedge clk);
      chk(!irq, "R3 not before limit", irq, 0);
      @(negedge clk);
      chk(irq, "R3 expiry edge", irq, 1);
      chk(!tmr_busy, "R6 halted", tmr_busy, 0);
      rd(8'h26, r); chk(r == 8'h01, "R7 status after expiry", r, 1);
      wr(8'h26, 8'h00); chk(irq, "R5 write 0 keeps flag", irq, 1);
      wr(8'h26, 8'h01); chk(!irq, "R5 W1C clears", irq, 0);
      repeat (3 * dur(v)) @(negedge clk);
      chk(!irq, "R6 no wrap re-expiry", irq, 0);
    end

    for (int v = 0; v < (1 << VW); v++) begin
      wr(8'h24, 8'(v));
      start();
      repeat (dur(v) - 1) @(negedge clk);
      host_ack = 1;
      @(negedge clk);
      host_ack = 0;
      chk(!irq, "R4 ack on expiry edge", irq, 0);
      chk(!tmr_busy, "R4 ack stops", tmr_busy, 0);
      repeat (2 * dur(v)) @(negedge clk);
      chk(!irq, "R4 no later expiry", irq, 0);
    end

    wr(8'h24, 8'd3);
    start();
    repeat (dur(3) / 2) @(negedge clk);
    host_ack = 1; @(negedge clk); host_ack = 0;
    repeat (2 * dur(3)) @(negedge clk);
    chk(!irq && !tmr_busy, "R4 early ack", {irq, tmr_busy}, 0);

    wr(8'h24, 8'd2);
    start();
    repeat (20) @(negedge clk);
    start();
    repeat (dur(2) - 1) @(negedge clk);
    chk(!irq, "R2 restart resets count", irq, 0);
    @(negedge clk);
    chk(irq, "R2 restart expiry", irq, 1);
    wr(8'h26, 8'h01);

    arm_start = 1; host_ack = 1; @(negedge clk); arm_start = 0; host_ack = 0;
    chk(tmr_busy, "R2 start beats ack", tmr_busy, 1);
    host_ack = 1; @(negedge clk); host_ack = 0;

    wr(8'h24, 8'd0);
    start();
    repeat (dur(0) - 1) @(negedge clk);
    wr(8'h26, 8'h01);
    chk(irq, "R5 set beats clear", irq, 1);
    wr(8'h26, 8'h01);

    epp_addr_in = 8'hA5; epp_addr_wr = 1; @(negedge clk); epp_addr_wr = 0;
    chk(epp_addr_out == 8'hA5, "R8 port capture", epp_addr_out, 8'hA5);
    rd(8'h25, r); chk(r == 8'hA5, "R8 bus readback", r, 8'hA5);
    wr(8'h25, 8'h3C);
    chk(epp_addr_out == 8'h3C, "R8 bus write", epp_addr_out, 8'h3C);
    epp_addr_in = 8'h77; epp_addr_wr = 1;
    wr(8'h25, 8'h11);
    epp_addr_wr = 0;
    chk(epp_addr_out == 8'h77, "R8 port wins", epp_addr_out, 8'h77);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule